// File: doc/BRIEF.md
# Two-Way LRU Word Cache

This block is a small word-addressed cache with two ways per set. Each request carries a word address, a direction flag and a data word. The low address bits select a set. The remaining upper bits form a tag, which is compared against both ways of that set at the same time. A matching valid way returns its word, or takes the new word on a write. An access that misses stalls the requester, fetches the word through a simple synchronous read port into a chosen way, and then completes. Each block holds a single word, so a write miss also fetches first and then overwrites the fetched word. Written data stays in the cache only.

Each set keeps one recency bit. The bit names the way that was not touched most recently. On a miss, an empty way is always filled before anything is evicted. Two counters tally hits and misses, so a known access trace can be checked against its expected totals.

The control is a three-state machine:
- IDLE accepts a request and moves to LOOKUP.
- LOOKUP compares the tags. On a hit it moves back to IDLE. On a miss it moves to FILL.
- FILL waits for the backing read to return, then moves back to IDLE.

Top module: `lru2_cache`

## Requirements
- R1: A synchronous active-high `rst` clears every valid bit, every recency bit and both counters. After reset `hit_count` and `miss_count` read 0, `req_ready` is 1, and every first access to an address is a miss.
- R2: The set index is the address modulo `SETS`, where `SETS` is a power of two. The tag is the address divided by `SETS`. Addresses in different sets never evict each other, and two addresses with the same index but different tags can be resident together.
- R3: A hit is reported only when a valid way of the indexed set holds the request tag. A request is accepted on an edge where `req_valid` and `req_ready` are both 1. On a hit, `resp_valid` is 1 in the cycle after the second edge counted from acceptance, with `resp_hit`=1 and the stored word on `resp_rdata` (or the written word for a write). `req_ready` is 1 whenever `resp_valid` is 1.
- R4: On a miss, `req_ready` stays 0 and `mem_rd_en` pulses for one cycle with `mem_rd_addr` equal to the request address. The response, with `resp_hit`=0, follows one edge after `mem_rd_valid` is sampled 1. A read returns `mem_rd_data`.
- R5: On a miss, a set with an invalid way fills the lowest-numbered invalid way, so the resident block is kept.
- R6: On a miss in a set whose two ways are both valid, the least recently used way is replaced.
- R7: Every completed access, whether a read or a write and whether a hit or a fill, marks its way as most recently used.
- R8: A write stores `req_wdata` in the accessed way. On a miss it replaces the fetched word. The write response returns the written word on `resp_rdata`.
- R9: `hit_count` rises by exactly one for each hit and `miss_count` by exactly one for each miss. Neither changes at any other time.
- R10: With 2 sets, starting from reset, the read trace 0, 2, 0, 1, 4, 0, 2, 3, 5, 4 gives exactly 2 hits, on the 3rd and 6th accesses, and 8 misses.
- R11: `resp_valid` and `mem_rd_en` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache idle and able to accept |
| req_addr | input | ADDR_W | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | Response was a hit |
| resp_rdata | output | DATA_W | Returned word |
| mem_rd_en | output | 1 | Backing read request pulse |
| mem_rd_addr | output | ADDR_W | Backing read address |
| mem_rd_valid | input | 1 | Backing read data present |
| mem_rd_data | input | DATA_W | Backing read data |
| hit_count | output | CNT_W | Hit tally |
| miss_count | output | CNT_W | Miss tally |

## Verification
A wrong recency bit or valid bit in this block stays hidden until the same set next misses. It then shows up as the wrong way being evicted. The error becomes visible only at the next access to the evicted address, as a miss where a hit was due (or the reverse), together with a `mem_rd_en` pulse that was not expected. For that reason the bench runs short directed sequences that reach the faulty decision within three or four accesses, and it also runs a long random mix over a few sets compared against a reference model. A wrong tag or stored word shows up on `resp_rdata` as soon as the line is hit, and a counter fault shows up one cycle after the response.

// File: rtl/lru2_pkg.sv
package lru2_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_FILL   = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/lru2_way.sv
module lru2_way #(
    parameter int SETS   = 2,
    parameter int TAG_W  = 7,
    parameter int DATA_W = 16,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SET_W-1:0]  set_idx,
    input  logic [TAG_W-1:0]  cmp_tag,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hit,
    output logic              valid_o,
    output logic [DATA_W-1:0] rd_data
);

    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[set_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[set_idx]  <= cmp_tag;
            data_q[set_idx] <= wr_data;
        end
    end

    assign valid_o = valid_q[set_idx];
    assign hit     = valid_q[set_idx] && (tag_q[set_idx] == cmp_tag);
    assign rd_data = data_q[set_idx];

endmodule

// File: rtl/lru2_repl.sv
module lru2_repl #(
    parameter int SETS = 2,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_idx,
    input  logic             valid0,
    input  logic             valid1,
    input  logic             touch_en,
    input  logic             touch_way,
    output logic             victim
);

    // one bit per set: the way not most recently used
    logic [SETS-1:0] older_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            older_q <= '0;
        end else if (touch_en) begin
            older_q[set_idx] <= ~touch_way;
        end
    end

    always_comb begin
        if (!valid0) begin
            victim = 1'b0;
        end else if (!valid1) begin
            victim = 1'b1;
        end else begin
            victim = older_q[set_idx];
        end
    end

endmodule

// File: rtl/lru2_stats.sv
module lru2_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_inc,
    input  logic             miss_inc,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_count  <= '0;
            miss_count <= '0;
        end else begin
            if (hit_inc)  hit_count  <= hit_count + 1'b1;
            if (miss_inc) miss_count <= miss_count + 1'b1;
        end
    end

endmodule

// File: rtl/lru2_cache.sv
module lru2_cache
    import lru2_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int SETS   = 2,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);

    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - SET_W;
    localparam int WAYS  = 2;

    ctl_state_e state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;
    logic              victim_q;

    logic [SET_W-1:0]  set_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [WAYS-1:0]   way_hit;
    logic [WAYS-1:0]   way_valid;
    logic [WAYS-1:0]   way_wr;
    logic [DATA_W-1:0] way_data [WAYS];
    logic [DATA_W-1:0] fill_word;
    logic [DATA_W-1:0] wr_word;
    logic              any_hit;
    logic              hit_way;
    logic              victim;
    logic              lookup_hit;
    logic              lookup_miss;
    logic              fill_done;

    assign set_idx = addr_q[SET_W-1:0];
    assign req_tag = addr_q[ADDR_W-1:SET_W];

    assign any_hit     = |way_hit;
    assign hit_way     = way_hit[1];
    assign lookup_hit  = (state_q == ST_LOOKUP) && any_hit;
    assign lookup_miss = (state_q == ST_LOOKUP) && !any_hit;
    assign fill_done   = (state_q == ST_FILL) && mem_rd_valid;
    assign fill_word   = write_q ? wdata_q : mem_rd_data;
    assign wr_word     = fill_done ? fill_word : wdata_q;
    assign req_ready   = (state_q == ST_IDLE);

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign way_wr[g] = (lookup_hit && write_q && way_hit[g])
                         || (fill_done && (victim_q == 1'(g)));

        lru2_way #(
            .SETS   (SETS),
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W)
        ) u_way (
            .clk     (clk),
            .rst     (rst),
            .set_idx (set_idx),
            .cmp_tag (req_tag),
            .wr_en   (way_wr[g]),
            .wr_data (wr_word),
            .hit     (way_hit[g]),
            .valid_o (way_valid[g]),
            .rd_data (way_data[g])
        );
    end

    lru2_repl #(
        .SETS (SETS)
    ) u_repl (
        .clk       (clk),
        .rst       (rst),
        .set_idx   (set_idx),
        .valid0    (way_valid[0]),
        .valid1    (way_valid[1]),
        .touch_en  (lookup_hit || fill_done),
        .touch_way (lookup_hit ? hit_way : victim_q),
        .victim    (victim)
    );

    lru2_stats #(
        .CNT_W (CNT_W)
    ) u_stats (
        .clk        (clk),
        .rst        (rst),
        .hit_inc    (lookup_hit),
        .miss_inc   (lookup_miss),
        .hit_count  (hit_count),
        .miss_count (miss_count)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = any_hit ? ST_IDLE : ST_FILL;
            ST_FILL:   if (mem_rd_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // registered outputs and request capture
    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid  <= 1'b0;
            resp_hit    <= 1'b0;
            resp_rdata  <= '0;
            mem_rd_en   <= 1'b0;
            mem_rd_addr <= '0;
            addr_q      <= '0;
            write_q     <= 1'b0;
            wdata_q     <= '0;
            victim_q    <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            mem_rd_en  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        write_q <= req_write;
                        wdata_q <= req_wdata;
                    end
                end
                ST_LOOKUP: begin
                    if (any_hit) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b1;
                        resp_rdata <= write_q ? wdata_q : way_data[hit_way];
                    end else begin
                        mem_rd_en   <= 1'b1;
                        mem_rd_addr <= addr_q;
                        victim_q    <= victim;
                    end
                end
                ST_FILL: begin
                    if (mem_rd_valid) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b0;
                        resp_rdata <= fill_word;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/lru2_cache_chk.sv
module lru2_cache_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_ready,
    input logic             resp_valid,
    input logic             resp_hit,
    input logic             mem_rd_en,
    input logic [CNT_W-1:0] hit_count,
    input logic [CNT_W-1:0] miss_count
);

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid); // R11

    AST_MEMRD_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en); // R11

    AST_FILL_STALL: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> !req_ready); // R4

    AST_RESP_READY: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> req_ready); // R3

    AST_HIT_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(hit_count) |-> (resp_valid && resp_hit
            && hit_count == CNT_W'($past(hit_count) + 1'b1))); // R9

    AST_MISS_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(miss_count) |-> (mem_rd_en
            && miss_count == CNT_W'($past(miss_count) + 1'b1))); // R9

endmodule

bind lru2_cache lru2_cache_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .mem_rd_en  (mem_rd_en),
    .hit_count  (hit_count),
    .miss_count (miss_count)
);

// File: tb/lru2_cache_tb_top.sv
`timescale 1ns/1ps
module lru2_cache_tb_top;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int SETS   = 2;
    localparam int CNT_W  = 16;
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - SET_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_write = 1'b0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              resp_valid;
    logic              resp_hit;
    logic [DATA_W-1:0] resp_rdata;
    logic              mem_rd_en;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic              mem_rd_valid = 1'b0;
    logic [DATA_W-1:0] mem_rd_data = '0;
    logic [CNT_W-1:0]  hit_count;
    logic [CNT_W-1:0]  miss_count;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lru2_cache #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .SETS (SETS), .CNT_W (CNT_W)
    ) dut_i (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .req_write (req_write), .req_wdata (req_wdata),
        .resp_valid (resp_valid), .resp_hit (resp_hit), .resp_rdata (resp_rdata),
        .mem_rd_en (mem_rd_en), .mem_rd_addr (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid), .mem_rd_data (mem_rd_data),
        .hit_count (hit_count), .miss_count (miss_count)
    );

    function automatic logic [DATA_W-1:0] memval(input logic [ADDR_W-1:0] a);
        return DATA_W'((32'(a) * 32'h0131) ^ 32'hA5C3);
    endfunction

    // backing store: data two edges after the request pulse
    logic              pend_q = 1'b0;
    logic [ADDR_W-1:0] pend_a = '0;
    always @(posedge clk) begin
        pend_q       <= mem_rd_en;
        pend_a       <= mem_rd_addr;
        mem_rd_valid <= pend_q;
        mem_rd_data  <= memval(pend_a);
    end

    // reference model
    bit                m_valid [SETS][2];
    logic [TAG_W-1:0]  m_tag   [SETS][2];
    logic [DATA_W-1:0] m_data  [SETS][2];
    bit                m_older [SETS];
    int                exp_hits;
    int                exp_misses;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < SETS; s++) begin
            m_older[s] = 1'b0;
            for (int w = 0; w < 2; w++) begin
                m_valid[s][w] = 1'b0;
                m_tag[s][w]   = '0;
                m_data[s][w]  = '0;
            end
        end
        exp_hits   = 0;
        exp_misses = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
        @(negedge clk);
        chk(hit_count == 0, "R1", "hit_count after reset", 32'(hit_count), 0);
        chk(miss_count == 0, "R1", "miss_count after reset", 32'(miss_count), 0);
        chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 1);
    endtask

    task automatic access(input logic [ADDR_W-1:0] a, input bit wr,
                          input logic [DATA_W-1:0] wd, input string htag,
                          output bit got_hit);
        int s;
        int way;
        int waited;
        bit exp_hit;
        bit saw_mem;
        bit stall_ok;
        logic [ADDR_W-1:0] mem_a;
        logic [TAG_W-1:0] t;
        logic [DATA_W-1:0] exp_d;
        s = int'(a) % SETS;
        t = TAG_W'(a >> SET_W);
        way = -1;
        for (int w = 0; w < 2; w++)
            if (m_valid[s][w] && m_tag[s][w] == t) way = w;
        exp_hit = (way >= 0);
        if (exp_hit) begin
            exp_d = wr ? wd : m_data[s][way];
        end else begin
            way = !m_valid[s][0] ? 0 : (!m_valid[s][1] ? 1 : int'(m_older[s]));
            exp_d = wr ? wd : memval(a);
        end

        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_write = wr;
        req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        waited = 1;
        saw_mem = 1'b0;
        stall_ok = 1'b1;
        mem_a = '0;
        while (!resp_valid && waited < 40) begin
            if (mem_rd_en) begin
                saw_mem = 1'b1;
                mem_a = mem_rd_addr;
                if (req_ready) stall_ok = 1'b0;
            end
            @(negedge clk);
            waited++;
        end
        got_hit = resp_hit;
        chk(resp_valid == 1'b1, htag, "response arrived", 32'(resp_valid), 1);
        chk(resp_hit == exp_hit, htag, "hit flag", 32'(resp_hit), 32'(exp_hit));
        chk(resp_rdata == exp_d, wr ? "R8" : (exp_hit ? "R3" : "R4"), "rdata",
            32'(resp_rdata), 32'(exp_d));
        chk(req_ready == 1'b1, "R3", "ready with response", 32'(req_ready), 1);
        if (exp_hit) begin
            chk(waited == 2, "R3", "hit latency", 32'(waited), 2);
            chk(!saw_mem, "R3", "no backing read on hit", 32'(saw_mem), 0);
        end else begin
            chk(waited == 5, "R4", "miss latency", 32'(waited), 5);
            chk(saw_mem && mem_a == a, "R4", "backing read address",
                32'(mem_a), 32'(a));
            chk(stall_ok, "R4", "stall during fill", 32'(stall_ok), 1);
        end

        m_valid[s][way] = 1'b1;
        m_tag[s][way]   = t;
        m_data[s][way]  = exp_d;
        m_older[s]      = (way == 0);
        if (exp_hit) exp_hits++; else exp_misses++;

        @(negedge clk);
        chk(!resp_valid, "R11", "response pulse width", 32'(resp_valid), 0);
        chk(int'(hit_count) == exp_hits, "R9", "hit_count", 32'(hit_count),
            32'(exp_hits));
        chk(int'(miss_count) == exp_misses, "R9", "miss_count", 32'(miss_count),
            32'(exp_misses));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        bit h;
        int trace [10] = '{0, 2, 0, 1, 4, 0, 2, 3, 5, 4};
        void'($urandom(32'd61));
        model_clear();
        chk(req_ready == 1'b0 || rst, "R1", "held in reset", 32'(rst), 1);
        do_reset();

        // R5: empty way filled before any eviction
        access(8'd0, 1'b0, '0, "R5", h);
        access(8'd2, 1'b0, '0, "R5", h);
        access(8'd0, 1'b0, '0, "R5", h);
        access(8'd2, 1'b0, '0, "R5", h);

        // R7 and R8: writes update recency and data
        do_reset();
        access(8'd0, 1'b1, 16'hBEEF, "R8", h);
        access(8'd2, 1'b1, 16'h1111, "R8", h);
        access(8'd0, 1'b1, 16'hC0DE, "R7", h);
        access(8'd4, 1'b0, '0, "R7", h);
        access(8'd0, 1'b0, '0, "R7", h);
        access(8'd2, 1'b0, '0, "R7", h);

        // R6: full set evicts least recently used
        do_reset();
        access(8'd1, 1'b0, '0, "R6", h);
        access(8'd3, 1'b0, '0, "R6", h);
        access(8'd5, 1'b0, '0, "R6", h);
        access(8'd3, 1'b0, '0, "R6", h);
        access(8'd1, 1'b0, '0, "R6", h);

        // R2: set index and tag split
        do_reset();
        access(8'd0, 1'b0, '0, "R2", h);
        access(8'd1, 1'b0, '0, "R2", h);
        access(8'd0, 1'b0, '0, "R2", h);
        access(8'd1, 1'b0, '0, "R2", h);
        access(8'd6, 1'b0, '0, "R2", h);
        access(8'd255, 1'b0, '0, "R2", h);

        // R10: reference trace
        do_reset();
        for (int i = 0; i < 10; i++) begin
            access(8'(trace[i]), 1'b0, '0, "R10", h);
            chk(h == (i == 2 || i == 5), "R10", "trace hit position",
                32'(h), 32'(i == 2 || i == 5));
        end
        chk(hit_count == 2, "R10", "trace hits", 32'(hit_count), 2);
        chk(miss_count == 8, "R10", "trace misses", 32'(miss_count), 8);

        // R3: random mix over a few tags
        do_reset();
        for (int i = 0; i < 400; i++) begin
            logic [ADDR_W-1:0] ra;
            bit rw;
            ra = ADDR_W'($urandom_range(0, 9));
            rw = ($urandom_range(0, 9) < 3);
            access(ra, rw, DATA_W'($urandom), "R3", h);
        end

        // R1: reset after traffic empties the cache
        do_reset();
        access(8'd0, 1'b0, '0, "R1", h);
        chk(!h, "R1", "first access after reset misses", 32'(h), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule